// File: doc/BRIEF.md
# Four-Bank Low-Order Interleaved Memory Controller

This block is a memory front end for a single requester. Each word address is split into a bank select (the two lowest bits) and a row (the remaining upper bits), so consecutive words fall in consecutive banks. Each of the four banks behaves like a slow storage device: once an access starts, that bank stays busy for `BANK_CYCLES` clock cycles. Accesses to different banks overlap freely, so a stream whose stride is odd keeps all four banks working in rotation and completes one access per cycle. A stream whose stride is a multiple of four lands on one bank and runs at the single-device rate.

Requests arrive on a valid/ready handshake, at most one per cycle. A request is taken only when its target bank is idle. Otherwise ready stays low and the request waits in place. Requests are never reordered. Reads return their data on a response strobe a fixed number of cycles after acceptance, which keeps responses in request order. Writes take the same bank time and return nothing. A counter records every cycle in which a valid request was refused. The bank storage is a set of plain behavioural arrays inside the block.

Top module: `interleaved_mem_ctrl`

## Requirements
- R1: The bank is `req_addr[1:0]` and the row is `req_addr[ADDR_W-1:2]`. A read of an address returns the data most recently written to that same address.
- R2: `req_ready` is high exactly when the bank selected by `req_addr` is idle, whatever the state of the other banks. A request is accepted in a cycle where `req_valid` and `req_ready` are both high.
- R3: After a bank accepts an access, it refuses further requests for `BANK_CYCLES-1` cycles. A request to that bank is accepted `BANK_CYCLES` cycles after the earlier one, and no sooner.
- R4: With `BANK_CYCLES` = 4, a stream of back-to-back requests with stride 1 or stride 3 is accepted at one request per cycle with zero stall cycles.
- R5: A read accepted in cycle t raises `rsp_valid` in cycle t+`BANK_CYCLES` for exactly one cycle, with its data on `rsp_rdata`. Responses come back in acceptance order.
- R6: A write is accepted under the same bank-busy rule as a read and never raises `rsp_valid`.
- R7: `stall_count` increases by one in every cycle in which `req_valid` is high and `req_ready` is low. It holds its value in all other cycles.
- R8: Reset (active-low `rst_n`) makes every bank idle, clears `stall_count` to 0, and drops `rsp_valid`. This also cancels any read that is still in flight.
- R9: With `BANK_CYCLES` = 4, a stream of 8 back-to-back requests with stride 2 costs 6 stall cycles, and one with stride 4 costs 21 stall cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Target bank idle; request taken this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address; low two bits select the bank |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data strobe |
| rsp_rdata | output | DATA_W | Read data |
| stall_count | output | STALL_W | Cycles a valid request was refused |

## Verification
The bench streams writes and then reads at strides 1, 3, 2 and 4. If a bank counter were off by one, the stride-4 and stride-2 stall totals would shift, and so would the exact gap measured between two accesses to one bank. If bank selection used the wrong bits, the odd strides would show stalls, or the read-back data would not match the address. A response pipeline one stage too short or too long is caught by comparing each strobe against its acceptance cycle. A write that leaked a response shows up as an unmatched strobe. Finally, a reset issued while a read is in flight must drop that response, clear the stall count and free the bank at once.

// File: rtl/interleaved_mem_ctrl.sv
module interleaved_mem_ctrl #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int BANK_CYCLES = 4,
  parameter int STALL_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [STALL_W-1:0] stall_count
);
  localparam int NBANKS = 4;
  localparam int SEL_W  = 2;
  localparam int ROW_W  = ADDR_W - SEL_W;
  localparam int ROWS   = 1 << ROW_W;
  localparam int CNT_W  = $clog2(BANK_CYCLES + 1);
  localparam int OUT_W  = CNT_W + 1;

  logic [SEL_W-1:0]  sel;
  logic [ROW_W-1:0]  row;
  logic [NBANKS-1:0] idle;
  logic [NBANKS-1:0] start;
  logic [DATA_W-1:0] bank_rd [NBANKS];
  logic              accept;

  assign sel       = req_addr[SEL_W-1:0];
  assign row       = req_addr[ADDR_W-1:SEL_W];
  assign req_ready = idle[sel];
  assign accept    = req_valid && req_ready;

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic [CNT_W-1:0]  busy;
    logic [CNT_W-1:0]  since;
    logic [DATA_W-1:0] mem [ROWS];

    assign start[b]   = accept && (sel == SEL_W'(b));
    assign idle[b]    = (busy == '0);
    assign bank_rd[b] = mem[row];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          busy <= '0;
      else if (start[b])   busy <= CNT_W'(BANK_CYCLES - 1);
      else if (busy != '0) busy <= busy - 1'b1;
    end

    always_ff @(posedge clk) begin
      if (start[b] && req_write) mem[row] <= req_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            since <= CNT_W'(BANK_CYCLES);
      else if (start[b])                     since <= CNT_W'(1);
      else if (since < CNT_W'(BANK_CYCLES))  since <= since + 1'b1;
    end

    // R3
    bank_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start[b] |-> since >= CNT_W'(BANK_CYCLES));
  end

  logic              pv [BANK_CYCLES];
  logic [DATA_W-1:0] pd [BANK_CYCLES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BANK_CYCLES; i++) pv[i] <= 1'b0;
    end else begin
      pv[0] <= accept && !req_write;
      for (int i = 1; i < BANK_CYCLES; i++) pv[i] <= pv[i-1];
    end
  end

  always_ff @(posedge clk) begin
    pd[0] <= bank_rd[sel];
    for (int i = 1; i < BANK_CYCLES; i++) pd[i] <= pd[i-1];
  end

  assign rsp_valid = pv[BANK_CYCLES-1];
  assign rsp_rdata = pd[BANK_CYCLES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       stall_count <= '0;
    else if (req_valid && !req_ready) stall_count <= stall_count + 1'b1;
  end

  // R7
  stall_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> stall_count == $past(stall_count) + 1'b1);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_ready) |=> $stable(stall_count));

  logic [OUT_W-1:0] reads_out;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reads_out <= '0;
    else        reads_out <= reads_out + OUT_W'(accept && !req_write) - OUT_W'(rsp_valid);
  end

  // R5
  rsp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> reads_out != '0);

  // R5
  inflight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reads_out <= OUT_W'(BANK_CYCLES));
endmodule

// File: tb/interleaved_mem_ctrl_test.sv
module interleaved_mem_ctrl_test;
  localparam int BC = 4;
  localparam int N  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [15:0] stall_count;

  interleaved_mem_ctrl #(.ADDR_W(8), .DATA_W(16), .BANK_CYCLES(BC), .STALL_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .stall_count(stall_count));

  always #10 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc++;

  // stride, expected stalls, base address
  localparam int TBL [4][3] = '{'{1, 0, 0}, '{3, 0, 64}, '{2, 6, 128}, '{4, 21, 192}};

  function automatic logic [15:0] pat(input logic [7:0] a);
    return {a, a ^ 8'hA5};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int          exp_cyc [64];
  logic [15:0] exp_dat [64];
  int          head = 0, tail = 0;

  initial forever begin
    @(negedge clk);
    #5;
    if (rsp_valid) begin
      if (head == tail) check(0, "R6 unexpected response", 1, 0);
      else begin
        check(cyc == exp_cyc[head % 64], "R5 response cycle", cyc, exp_cyc[head % 64]);
        check(rsp_rdata == exp_dat[head % 64], "R1 read data", rsp_rdata, exp_dat[head % 64]);
        head++;
      end
    end else if (head != tail && exp_cyc[head % 64] <= cyc) begin
      check(0, "R5 missing response", cyc, exp_cyc[head % 64]);
      head++;
    end
    if (rst_n && req_valid && req_ready && !req_write) begin
      exp_cyc[tail % 64] = cyc + BC;
      exp_dat[tail % 64] = pat(req_addr);
      tail++;
    end
  end

  task automatic issue(input bit wr, input logic [7:0] a, output int waits);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = pat(a);
    waits = 0;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1;
      waits++;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    check(0, "watchdog", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    req_valid = 1'b1; req_addr = 8'd0;
    #1;
    check(req_ready == 1'b1, "R8 ready after reset", req_ready, 1);
    check(stall_count == 0, "R8 stall count after reset", stall_count, 0);
    check(rsp_valid == 1'b0, "R8 no response in reset", rsp_valid, 0);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int p = 0; p < 4; p++) begin
      for (int ph = 0; ph < 2; ph++) begin
        int s0, tot;
        s0 = stall_count; tot = 0;
        for (int k = 0; k < N; k++) begin
          issue(ph == 0, 8'(TBL[p][2] + k * TBL[p][0]), w);
          tot += w;
        end
        // R4 (odd strides) and R9 (strides 2 and 4)
        check(tot == TBL[p][1], "R4/R9 refused cycles for stride", tot, TBL[p][1]);
        check(int'(stall_count) - s0 == TBL[p][1], "R7 stall counter delta", int'(stall_count) - s0, TBL[p][1]);
        repeat (2 * BC) @(negedge clk);
      end
    end

    // R3: same bank back to back
    issue(1'b0, 8'd1, w);
    issue(1'b0, 8'd5, w);
    check(w == BC - 1, "R3 same-bank refused cycles", w, BC - 1);
    repeat (2 * BC) @(negedge clk);

    // R2: other bank ready while one is busy
    issue(1'b1, 8'd6, w);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'd10;
    #1;
    check(req_ready == 1'b0, "R2 busy bank refuses", req_ready, 0);
    req_addr = 8'd3;
    #1;
    check(req_ready == 1'b1, "R2 idle bank accepts", req_ready, 1);
    issue(1'b0, 8'd3, w);
    repeat (2 * BC) @(negedge clk);

    // R6: writes produce no response
    issue(1'b1, 8'd7, w);
    for (int i = 0; i < BC + 3; i++) begin
      #5;
      check(rsp_valid == 1'b0, "R6 no response after write", rsp_valid, 0);
      @(negedge clk);
    end

    // R8: reset with a read in flight
    issue(1'b0, 8'd0, w);
    @(negedge clk);
    rst_n = 1'b0;
    head = tail;
    #1;
    check(rsp_valid == 1'b0, "R8 response dropped", rsp_valid, 0);
    check(stall_count == 0, "R8 stall count cleared", stall_count, 0);
    @(negedge clk);
    rst_n = 1'b1;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'd4;
    #1;
    check(req_ready == 1'b1, "R8 bank freed by reset", req_ready, 1);
    issue(1'b0, 8'd4, w);
    repeat (3 * BC) @(negedge clk);
    check(head == tail, "R5 all responses returned", tail - head, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule